// File: doc/BRIEF.md
# Request-Paced Single-Word DMA Channel With Post-Transfer Hold-Off

This block is one DMA channel that moves 32-bit words between system memory and one fixed peripheral data register. A request line from the peripheral paces the transfers. Each request sampled high starts exactly one word. The word is read from its source and then written to its destination over a simple strobe-and-ready bus port. Bursts of several words are never issued.

Some peripherals drop their request several clocks after the word has been taken. To avoid a spurious extra word, the channel ignores the request line for a programmable number of cycles after each word. The hold-off count can come from a 2-bit field. It can also come from a built-in table that depends on the transfer mode and the direction.

Software programs the length, the memory start address, the peripheral register address and the direction, then raises the enable. The channel finishes on its own when the word count reaches zero, and it signals this with a one-cycle completion pulse. Dropping the enable stops the channel once the word in flight has been written.

Top module: `wsdma_channel`

## Requirements
- R1: After reset the channel is idle: `busy`, `bus_rd`, `bus_wr` and `done` are all low.
- R2: A job starts on the cycle after a rising edge of `cfg_enable` when `cfg_count` is non-zero. Direction, hold-off, peripheral address, memory address and count are captured at that edge; later changes to these inputs do not affect the running job.
- R3: Each request sampled high while armed produces one word and no more. First comes a read phase, with `bus_rd` high until `bus_ready`, on the cycle after the request is sampled. Then comes a write phase, with `bus_wr` high until `bus_ready`, on the next cycle. `bus_rd` and `bus_wr` are never high together.
- R4: With `cfg_to_periph`=0 the read phase addresses the peripheral register and the write phase addresses memory. With `cfg_to_periph`=1 the two are swapped. The write data is the word returned on `bus_rdata` in the read phase.
- R5: The memory address advances by 4 after each completed word. The peripheral address never changes.
- R6: After a word completes (write phase with `bus_ready`), the request line is ignored for exactly W cycles, where W is the captured hold-off. It is sampled again on the next cycle. With the request held high and `bus_ready` always high, the next read phase starts W+1 cycles after the word completes.
- R7: The hold-off value in force during a job is the one captured at start. `cfg_wait` changes during the job have no effect.
- R8: Each completed word lowers the remaining count by one. When the count reaches zero, `done` is high for exactly one cycle, on the cycle after the last write is accepted, and the channel returns to idle.
- R9: With no words left, or after a job with zero count is requested, no bus strobe is issued and `busy` stays low, whatever `periph_req` does, until a new rising edge of `cfg_enable`.
- R10: If `cfg_enable` falls during a job, the word already in its read or write phase is completed and the channel then goes idle without a `done` pulse. A channel that is armed or in hold-off goes idle at once.
- R11: With `cfg_use_table`=1 the hold-off is taken from a table instead of `cfg_wait`. Normal mode (`cfg_fast_mode`=0) gives 0 for peripheral-to-memory and 3 for memory-to-peripheral. Fast mode (`cfg_fast_mode`=1) gives 1 and 2 for the same two directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Job enable; a rising edge starts a job |
| cfg_to_periph | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_fast_mode | input | 1 | Selects the fast-mode column of the hold-off table |
| cfg_use_table | input | 1 | 1: hold-off from the table, 0: from `cfg_wait` |
| cfg_wait | input | 2 | Hold-off cycles after each word |
| cfg_count | input | CW | Number of words in the job |
| cfg_mem_addr | input | AW | Memory start address |
| cfg_periph_addr | input | AW | Peripheral data register address |
| periph_req | input | 1 | Peripheral transfer request |
| bus_rd | output | 1 | Read command strobe |
| bus_wr | output | 1 | Write command strobe |
| bus_addr | output | AW | Address of the current command, zero when idle |
| bus_wdata | output | DW | Write data, zero outside the write phase |
| bus_rdata | input | DW | Read data, taken when `bus_rd` and `bus_ready` are high |
| bus_ready | input | 1 | Completes the current read or write command |
| busy | output | 1 | A job is active |
| done | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The assertions assume that `bus_ready` completes a command within one cycle of being seen and that a command is never withdrawn by the bus. They also assume that the configuration inputs are settled on the cycle in which the enable rises. The request line may stay high for any length of time and may toggle freely. The stimulus sets every configuration field one cycle before the enable edge. It lets `bus_ready` stall at random in some jobs and holds the request high through whole jobs, so that any hold-off that is too short shows up as an early read phase. It changes `cfg_wait` and the memory address only while a job is already running, to confirm that the captured values stay in force.

// File: rtl/wsdma_pkg.sv
package wsdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_FETCH = 3'd2,
        ST_STORE = 3'd3,
        ST_HOLD  = 3'd4
    } wsdma_state_e;

    localparam int TBL_W = 2;

    // Hold-off table: normal mode 0 (to memory) / 3 (to peripheral),
    // fast mode 1 (to memory) / 2 (to peripheral).
    function automatic logic [TBL_W-1:0] wsdma_table_wait(input logic fast,
                                                          input logic to_periph);
        logic [TBL_W-1:0] w;
        unique case ({fast, to_periph})
            2'b00:   w = 2'd0;
            2'b01:   w = 2'd3;
            2'b10:   w = 2'd1;
            default: w = 2'd2;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/wsdma_wait_ctr.sv
module wsdma_wait_ctr #(
    parameter int WW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [WW-1:0] load_val_i,
    input  logic          tick_i,
    output logic          last_o
);

    logic [WW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == WW'(1));

    AST_TICK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |-> (cnt_q != '0)); // R6

    AST_NO_LOAD_WHILE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && tick_i)); // R6

endmodule

// File: rtl/wsdma_xfer_ctr.sv
module wsdma_xfer_ctr #(
    parameter int CW = 16,
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] cnt_val_i,
    input  logic [AW-1:0] addr_val_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o,
    output logic          zero_o
);

    localparam int STRIDE = DW / 8;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        cnt_d  = cnt_q;
        addr_d = addr_q;
        if (load_i) begin
            cnt_d  = cnt_val_i;
            addr_d = addr_val_i;
        end else if (step_i) begin
            cnt_d  = cnt_q - 1'b1;
            addr_d = addr_q + AW'(STRIDE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;
    assign last_o = (cnt_q == CW'(1));
    assign zero_o = (cnt_q == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (cnt_q != '0)); // R8

    AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (addr_q == $past(addr_q) + AW'(STRIDE))); // R5

endmodule

// File: rtl/wsdma_channel.sv
module wsdma_channel
    import wsdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16,
    parameter int WW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic          cfg_to_periph,
    input  logic          cfg_fast_mode,
    input  logic          cfg_use_table,
    input  logic [WW-1:0] cfg_wait,
    input  logic [CW-1:0] cfg_count,
    input  logic [AW-1:0] cfg_mem_addr,
    input  logic [AW-1:0] cfg_periph_addr,
    input  logic          periph_req,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic          busy,
    output logic          done
);

    typedef struct packed {
        wsdma_state_e  state;
        logic          en_prev;
        logic          to_periph;
        logic [WW-1:0] wait_n;
        logic [AW-1:0] paddr;
        logic [DW-1:0] data;
        logic          done;
    } ctl_t;

    ctl_t q, d;

    logic          start;
    logic [WW-1:0] wait_sel;
    logic          xfer_load, xfer_step, xfer_last, xfer_zero;
    logic          wait_load, wait_tick, wait_last;
    logic [AW-1:0] mem_addr;

    assign wait_sel = cfg_use_table ? WW'(wsdma_table_wait(cfg_fast_mode, cfg_to_periph))
                                    : cfg_wait;
    assign start    = cfg_enable && !q.en_prev && (cfg_count != '0);

    always_comb begin
        d         = q;
        d.en_prev = cfg_enable;
        d.done    = 1'b0;
        xfer_load = 1'b0;
        xfer_step = 1'b0;
        wait_load = 1'b0;
        wait_tick = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state     = ST_ARMED;
                    d.to_periph = cfg_to_periph;
                    d.wait_n    = wait_sel;
                    d.paddr     = cfg_periph_addr;
                    xfer_load   = 1'b1;
                end
            end
            ST_ARMED: begin
                if (!cfg_enable) begin
                    d.state = ST_IDLE;
                end else if (periph_req && !xfer_zero) begin
                    d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (bus_ready) begin
                    d.data  = bus_rdata;
                    d.state = ST_STORE;
                end
            end
            ST_STORE: begin
                if (bus_ready) begin
                    xfer_step = 1'b1;
                    if (xfer_last) begin
                        d.done  = 1'b1;
                        d.state = ST_IDLE;
                    end else if (!cfg_enable) begin
                        d.state = ST_IDLE;
                    end else if (q.wait_n == '0) begin
                        d.state = ST_ARMED;
                    end else begin
                        wait_load = 1'b1;
                        d.state   = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (!cfg_enable) begin
                    d.state = ST_IDLE;
                end else begin
                    wait_tick = 1'b1;
                    if (wait_last) begin
                        d.state = ST_ARMED;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, en_prev: 1'b0, to_periph: 1'b0, wait_n: '0,
                   paddr: '0, data: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    wsdma_xfer_ctr #(
        .CW(CW),
        .AW(AW),
        .DW(DW)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (xfer_load),
        .cnt_val_i  (cfg_count),
        .addr_val_i (cfg_mem_addr),
        .step_i     (xfer_step),
        .addr_o     (mem_addr),
        .last_o     (xfer_last),
        .zero_o     (xfer_zero)
    );

    wsdma_wait_ctr #(
        .WW(WW)
    ) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wait_load),
        .load_val_i (q.wait_n),
        .tick_i     (wait_tick),
        .last_o     (wait_last)
    );

    always_comb begin
        bus_addr = '0;
        if (q.state == ST_FETCH) begin
            bus_addr = q.to_periph ? mem_addr : q.paddr;
        end else if (q.state == ST_STORE) begin
            bus_addr = q.to_periph ? q.paddr : mem_addr;
        end
    end

    assign bus_rd    = (q.state == ST_FETCH);
    assign bus_wr    = (q.state == ST_STORE);
    assign bus_wdata = (q.state == ST_STORE) ? q.data : '0;
    assign busy      = (q.state != ST_IDLE);
    assign done      = q.done;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R3

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ready) |=> bus_wr); // R3

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> $past(bus_rd)); // R3

    AST_HOLD_MASKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ready && !xfer_last && q.wait_n != '0) |=> !bus_rd); // R6

    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_zero |-> (!bus_rd && !bus_wr)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_wr && bus_ready)); // R8

    AST_WAIT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.wait_n)); // R7

endmodule

// File: tb/wsdma_channel_test.sv
module wsdma_channel_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0;
    logic          cfg_to_periph = 1'b0;
    logic          cfg_fast_mode = 1'b0;
    logic          cfg_use_table = 1'b0;
    logic [1:0]    cfg_wait = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [AW-1:0] cfg_mem_addr = '0;
    logic [AW-1:0] cfg_periph_addr = '0;
    logic          periph_req = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b0;
    logic          bus_rd, bus_wr, busy, done;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    wsdma_channel uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_to_periph(cfg_to_periph), .cfg_fast_mode(cfg_fast_mode),
        .cfg_use_table(cfg_use_table), .cfg_wait(cfg_wait), .cfg_count(cfg_count),
        .cfg_mem_addr(cfg_mem_addr), .cfg_periph_addr(cfg_periph_addr),
        .periph_req(periph_req), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int ncyc = 0;

    // stimulus modes: req 0 = high, 1 = random, 2 = low; ready 0 = high, 1 = random
    int req_mode = 2;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference model
    int          m_phase = 0;   // 0 idle, 1 armed, 2 read, 3 write, 4 hold-off
    int          m_cnt = 0;
    int          m_wait = 0;
    int          m_hold = 0;
    logic        m_to = 1'b0;
    logic        m_en_prev = 1'b0;
    logic        m_done = 1'b0;
    logic [AW-1:0] m_addr = '0;
    logic [AW-1:0] m_paddr = '0;
    logic [DW-1:0] m_data = '0;

    // observation counters
    int   words = 0;
    int   dones = 0;
    int   strobes = 0;
    int   last_fin = 0;
    int   last_gap = 0;
    logic prev_wr = 1'b0;
    logic prev_rd = 1'b0;
    logic rdy_edge = 1'b0;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int table_wait(input logic fast, input logic to_p);
        if (fast) return to_p ? 2 : 1;
        return to_p ? 3 : 0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
        rdy_edge = bus_ready;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_en_prev = 1'b0; m_done = 1'b0;
            m_data = '0; m_paddr = '0; m_addr = '0;
        end else begin
            m_done = 1'b0;
            case (m_phase)
                0: if (cfg_enable && !m_en_prev && cfg_count != 0) begin
                       m_to    = cfg_to_periph;
                       m_wait  = cfg_use_table ? table_wait(cfg_fast_mode, cfg_to_periph)
                                               : int'(cfg_wait);
                       m_paddr = cfg_periph_addr;
                       m_addr  = cfg_mem_addr;
                       m_cnt   = int'(cfg_count);
                       m_phase = 1;
                   end
                1: if (!cfg_enable) m_phase = 0;
                   else if (periph_req) m_phase = 2;
                2: if (bus_ready) begin m_data = bus_rdata; m_phase = 3; end
                3: if (bus_ready) begin
                       m_cnt  = m_cnt - 1;
                       m_addr = m_addr + 4;
                       if (m_cnt == 0) begin m_done = 1'b1; m_phase = 0; end
                       else if (!cfg_enable) m_phase = 0;
                       else if (m_wait == 0) m_phase = 1;
                       else begin m_hold = m_wait; m_phase = 4; end
                   end
                4: if (!cfg_enable) m_phase = 0;
                   else begin
                       m_hold = m_hold - 1;
                       if (m_hold == 0) m_phase = 1;
                   end
                default: m_phase = 0;
            endcase
            m_en_prev = cfg_enable;
        end
    end

    // per-clock comparison and observation, away from the active edge
    always @(negedge clk) begin
        logic [AW-1:0] e_addr;
        logic [DW-1:0] e_wdata;
        ncyc++;
        if (rst_n) begin
            e_addr  = '0;
            e_wdata = '0;
            if (m_phase == 2) e_addr = m_to ? m_addr : m_paddr;
            if (m_phase == 3) begin
                e_addr  = m_to ? m_paddr : m_addr;
                e_wdata = m_data;
            end
            check(bus_rd == (m_phase == 2), "R3 R6 R10 bus_rd", bus_rd, m_phase == 2);
            check(bus_wr == (m_phase == 3), "R3 bus_wr", bus_wr, m_phase == 3);
            check(bus_addr == e_addr, "R4 R5 R2 bus_addr", bus_addr, e_addr);
            check(bus_wdata == e_wdata, "R4 bus_wdata", bus_wdata, e_wdata);
            check(busy == (m_phase != 0), "R2 R9 busy", busy, m_phase != 0);
            check(done == m_done, "R8 done", done, m_done);
            if (prev_wr && rdy_edge) begin
                words++;
                last_fin = ncyc;
            end
            if (bus_rd && !prev_rd) last_gap = ncyc - last_fin;
            if (done) dones++;
            if (bus_rd || bus_wr) strobes++;
        end
        prev_wr = bus_wr;
        prev_rd = bus_rd;
    end

    // input driver for request line and bus responder
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        periph_req <= (req_mode == 0) ? 1'b1 : (req_mode == 1) ? lfsr[3] : 1'b0;
        bus_ready  <= (rdy_mode == 0) ? 1'b1 : (lfsr[1] | lfsr[5]);
        bus_rdata  <= {lfsr, ncyc[15:0]};
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    int w0, d0;

    task automatic start_job(input bit to_p, input bit fast, input bit tbl,
                             input logic [1:0] w, input int cnt,
                             input logic [AW-1:0] maddr, input logic [AW-1:0] paddr);
        cfg_to_periph   = to_p;
        cfg_fast_mode   = fast;
        cfg_use_table   = tbl;
        cfg_wait        = w;
        cfg_count       = CW'(cnt);
        cfg_mem_addr    = maddr;
        cfg_periph_addr = paddr;
        tick(1);
        w0 = words;
        d0 = dones;
        cfg_enable = 1'b1;
        tick(2);
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 5000 && m_phase != 0; g++) tick(1);
    endtask

    task automatic finish_job(input int exp_words, input string tag);
        int s0;
        wait_idle();
        tick(1);
        // R9: with no words left, a high request must not start anything
        s0 = strobes;
        req_mode = 0;
        tick(15);
        check(strobes - s0 == 0, "R9 strobes after count reached zero", strobes - s0, 0);
        check(busy == 1'b0, "R9 busy after count reached zero", busy, 0);
        cfg_enable = 1'b0;
        tick(2);
        check(words - w0 == exp_words, {tag, " R8 words moved"}, words - w0, exp_words);
        check(dones - d0 == (exp_words > 0 ? 1 : 0), {tag, " R8 done pulses"},
              dones - d0, exp_words > 0 ? 1 : 0);
    endtask

    initial begin
        int k;
        tick(3);
        // R1: reset state
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(bus_rd == 1'b0 && bus_wr == 1'b0, "R1 strobes in reset", {bus_rd, bus_wr}, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        rst_n = 1'b1;
        tick(2);
        check(busy == 1'b0, "R1 idle after reset", busy, 0);

        // peripheral to memory, no hold-off, request stuck high (R3 R4 R5 R6)
        req_mode = 0; rdy_mode = 0;
        start_job(1'b0, 1'b0, 1'b0, 2'd0, 5, 32'h1000_0000, 32'h8000_0040);
        wait_idle();
        check(last_gap == 1, "R6 gap with hold-off 0", last_gap, 1);
        finish_job(5, "S2");

        // memory to peripheral, hold-off 3 (R6)
        req_mode = 0; rdy_mode = 0;
        start_job(1'b1, 1'b0, 1'b0, 2'd3, 4, 32'h2000_0100, 32'h8000_0080);
        wait_idle();
        check(last_gap == 4, "R6 gap with hold-off 3", last_gap, 4);
        finish_job(4, "S3");

        // random request and ready (R3 R4 R5)
        req_mode = 1; rdy_mode = 1;
        start_job(1'b1, 1'b0, 1'b0, 2'd2, 6, 32'h3000_0000, 32'h8000_0000);
        finish_job(6, "S4");

        // R11: table-driven hold-off, for every mode and direction
        for (int i = 0; i < 4; i++) begin
            logic fm, tp;
            int exp_gap;
            fm = i[1];
            tp = i[0];
            exp_gap = table_wait(fm, tp) + 1;
            req_mode = 0; rdy_mode = 0;
            start_job(tp, fm, 1'b1, 2'd0, 3, 32'h4000_0000 + 32'(i * 256), 32'h8000_0100);
            wait_idle();
            check(last_gap == exp_gap, "R11 table hold-off gap", last_gap, exp_gap);
            finish_job(3, "R11");
        end

        // R7 R2: change hold-off and memory address during the job
        req_mode = 0; rdy_mode = 0;
        start_job(1'b0, 1'b0, 1'b0, 2'd1, 5, 32'h5000_0000, 32'h8000_0200);
        tick(2);
        cfg_wait = 2'd3;
        cfg_mem_addr = 32'hDEAD_0000;
        cfg_count = CW'(9);
        wait_idle();
        check(last_gap == 2, "R7 hold-off kept at captured value", last_gap, 2);
        finish_job(5, "R7 R2");

        // R9: zero-length job must not start
        req_mode = 0;
        start_job(1'b0, 1'b0, 1'b0, 2'd0, 0, 32'h6000_0000, 32'h8000_0300);
        tick(10);
        check(busy == 1'b0, "R9 zero count keeps channel idle", busy, 0);
        finish_job(0, "R9");

        // R10: drop the enable while a word is being read
        req_mode = 0; rdy_mode = 1;
        start_job(1'b1, 1'b0, 1'b0, 2'd0, 8, 32'h7000_0000, 32'h8000_0400);
        for (int g = 0; g < 2000 && !((words - w0) >= 2 && bus_rd); g++) tick(1);
        k = words - w0;
        cfg_enable = 1'b0;
        wait_idle();
        tick(2);
        check(words - w0 == k + 1, "R10 word in flight completes", words - w0, k + 1);
        check(dones - d0 == 0, "R10 no done after abort", dones - d0, 0);
        check(busy == 1'b0, "R10 idle after abort", busy, 0);

        tick(3);
        summary();
        $finish;
    end

endmodule